// File: doc/BRIEF.md
# Iterative shift-and-add multiplier

This block multiplies two W-bit operands over W clock cycles, using one adder. A one-cycle `start` strobe on an idle block latches the multiplicand, the multiplier and the operand mode, and clears the upper half of the result register. Each busy cycle then looks at the low bit of the multiplier register and adds the multiplicand, or nothing, to the upper half. The add result has one extra bit. The whole double-width register then moves right by one place, so the multiplier bits are used up from the bottom while product bits fill in from the top.

The mode input selects the number format. When it is 0, operands are unsigned and the carry of each add enters the top of the register. When it is 1, operands are two's complement. Each add is then sign-extended, and on the final step, which handles the multiplier's top bit, the multiplicand is subtracted instead of added. The 2W-bit product is available when `done` pulses, and it holds until the next accepted start.

Top module: `seq_mul`

## Requirements
- R1: While reset is active, and after it until the first start, `busy` and `done` are 0 and `product` is 0.
- R2: A `start` sampled while `busy` is 0 is accepted. `busy` is 1 from the next cycle for exactly W cycles.
- R3: `done` is 1 for exactly one cycle. That cycle is the first cycle in which `busy` is 0 again after a run.
- R4: With `is_signed`=0, `product` equals `mcand` times `mplier` as unsigned numbers. This includes zero and all-ones operands.
- R5: With `is_signed`=1, `product` equals the two's-complement product as a 2W-bit two's-complement value. This includes operands equal to the most negative value and to -1.
- R6: A `start` sampled while `busy` is 1 has no effect: it does not change the running result or the time `done` arrives.
- R7: After `done`, `product` keeps its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiply when idle |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| mcand | input | W | Multiplicand |
| mplier | input | W | Multiplier |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle result-ready pulse |
| product | output | 2W | Result register |

## Verification
Completion and a new start can fall in the same cycle: `done` is high, `busy` has just dropped, and a fresh `start` is presented. The bench provokes this by raising `start` in the very cycle it sees `done`. The reference model must then hold the finished product for that cycle and begin a full W-cycle run on the next edge. The bench also raises `start` in the middle of a run. Here the model requires that `done` arrives on schedule and that the product still matches the original operands.

// File: rtl/seq_mul.sv
module seq_mul #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           is_signed,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  a_q, p_q, b_q;
  logic [CW-1:0] cnt_q;
  logic          sgn_q;

  logic          last;
  logic [W:0]    p_ext, a_ext, sum;

  assign last  = (cnt_q == CW'(W - 1));
  assign p_ext = {sgn_q & p_q[W-1], p_q};
  assign a_ext = b_q[0] ? {sgn_q & a_q[W-1], a_q} : '0;
  assign sum   = (sgn_q && last) ? p_ext - a_ext : p_ext + a_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q   <= '0;
      p_q   <= '0;
      b_q   <= '0;
      cnt_q <= '0;
      sgn_q <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        p_q   <= sum[W:1];
        b_q   <= {sum[0], b_q[W-1:1]};
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        a_q   <= mcand;
        b_q   <= mplier;
        p_q   <= '0;
        cnt_q <= '0;
        sgn_q <= is_signed;
        busy  <= 1'b1;
      end
    end
  end

  assign product = {p_q, b_q};

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && !done);                               // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                 // R3
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                           // R3
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy && $stable(a_q) && $stable(sgn_q));       // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(product));                           // R7
endmodule

// File: tb/seq_mul_test.sv
`timescale 1ns/1ps
module seq_mul_test;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic           is_signed = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  seq_mul #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .mcand(mcand), .mplier(mplier), .busy(busy), .done(done), .product(product)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  logic           m_busy = 1'b0;
  logic           m_done = 1'b0;
  logic [2*W-1:0] m_prod = '0;
  logic [2*W-1:0] m_res = '0;
  int             m_cnt = 0;
  bit             m_started = 1'b0;
  string          m_tag = "R1";

  function automatic logic [2*W-1:0] ref_mul(logic [W-1:0] a, logic [W-1:0] b, logic s);
    logic [2*W-1:0] xa, xb;
    xa = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    xb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
    return xa * xb;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_prod = '0; m_cnt = 0; m_started = 0; m_tag = "R1";
    end else if (m_busy) begin
      if (start) m_tag = "R6";
      m_cnt++;
      if (m_cnt == W) begin
        m_busy = 0; m_done = 1; m_prod = m_res;
      end
    end else begin
      m_done = 0;
      if (start) begin
        m_busy = 1; m_cnt = 0; m_started = 1;
        m_res = ref_mul(mcand, mplier, is_signed);
        m_tag = is_signed ? "R5" : "R4";
      end else if (m_started) begin
        m_tag = "R7";
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: got cycle %0d expected finish", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    checks++;
    if (busy !== m_busy) begin
      fails++;
      $display("FAIL %s R2 busy: got %b expected %b", m_tag, busy, m_busy);
    end
    checks++;
    if (done !== m_done) begin
      fails++;
      $display("FAIL %s R3 done: got %b expected %b", m_tag, done, m_done);
    end
    if (!m_busy) begin
      checks++;
      if (product !== m_prod) begin
        fails++;
        $display("FAIL %s product: got %h expected %h", m_tag, product, m_prod);
      end
    end
  end

  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic s, bit inject);
    start = 1; mcand = a; mplier = b; is_signed = s;
    @(negedge clk);
    start = 0; mcand = $urandom; mplier = $urandom; is_signed = $urandom;
    if (inject) begin
      // R6: start with other operands while running
      repeat (2) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);   // R1 reset state checked each cycle
    rst_n = 1;
    repeat (3) @(negedge clk);   // R1 idle after reset
    for (int s = 0; s < 2; s++) begin
      run_op('0, '0, s[0], 0);                         // R4 / R5 zeros
      run_op('0, '1, s[0], 0);
      run_op('1, '1, s[0], 0);                         // R4 all-ones, R5 -1*-1
      run_op({1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, s[0], 0);
      run_op({1'b1, {(W-1){1'b0}}}, '1, s[0], 0);      // R5 most negative
      run_op({1'b1, {(W-1){1'b0}}}, {1'b0, {(W-1){1'b1}}}, s[0], 1);
      repeat (4) @(negedge clk);                       // R7 hold
    end
    for (int i = 0; i < 300; i++) begin
      run_op(W'($urandom), W'($urandom), 1'($urandom), ($urandom % 4) == 0);
      if ($urandom % 2) repeat ($urandom % 4) @(negedge clk);  // else start in done cycle
    end
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule